// File: doc/BRIEF.md
# Latched-Address Active-Low Decoder

This block turns a select address into a set of mutually exclusive active-low strobes. A small address register sits in front of the decoder. While the latch-enable input is low, the register reloads from the address pins on every clock, so the strobes track the pins with one cycle of delay. Once latch-enable is seen high on a clock edge, the register stops loading. It then holds the last address it took in while latch-enable was low, and address changes on the pins do nothing.

Two output enables of opposite polarity gate every strobe. This gating is combinational and does not depend on the register. A strobe can be low only while the active-low enable is 0 and the active-high enable is 1. In every other combination all strobes are high. Turning the enables off and back on leaves the stored address as it was. A typical use is a strobed address decoder on a shared bus: the address is captured once, and the enables then pulse the selected line.

The model is synchronous to a system clock and has a synchronous active-low reset.

Top module: `latched_addr_decoder`

## Requirements
- R1: A clock edge with `rst_n` low clears the stored address to 0. While the gate is open after that edge, `dec_n[0]` is the only low strobe.
- R2: On a clock edge with `rst_n` high and `lat_en` low, the stored address loads `addr_in`. From that edge on, the strobes decode the new value.
- R3: On a clock edge with `lat_en` high, the stored address keeps its value. Any change on `addr_in` while `lat_en` stays high leaves the strobes unchanged.
- R4: The gate is open only when `en_lo_n` is 0 and `en_hi` is 1. When the gate is closed, all bits of `dec_n` are 1. This follows the enables in the same cycle, without waiting for a clock.
- R5: While the gate is open, exactly one bit of `dec_n` is 0. That bit is `dec_n[k]`, where k is the stored address read as an unsigned binary number.
- R6: Closing and reopening the gate has no effect on the stored address. After reopening, the same strobe goes low as before.
- R7: At most one bit of `dec_n` is 0 in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| addr_in | input | ADDR_W (3) | Select address |
| lat_en | input | 1 | 0 = register loads every clock, 1 = register holds |
| en_lo_n | input | 1 | Active-low output enable |
| en_hi | input | 1 | Active-high output enable |
| dec_n | output | 2**ADDR_W (8) | Active-low one-hot strobes |

## Verification
The assertions check the following on every cycle:
- No more than one strobe is ever low.
- A closed gate forces all strobes high.
- An open gate gives exactly one low strobe.
- After a load edge, the low strobe matches the address sampled at that edge.
- The strobes stay still while the register is holding and the gate stays open.
- Reset selects strobe 0.

Some behaviour can only be shown by the bench's scenarios. One case is that the held address is the one from the last loading edge, even after many address changes and several gate close and reopen cycles. The others are the full sweep of all eight addresses under all four enable combinations, and random interleavings of latch and enable activity.

// File: rtl/adl_pkg.sv
// Package: shared constants and the enable-pair type for the latched decoder.
// Assumes: nothing; holds no logic beyond a small helper.
package adl_pkg;
    localparam int ADL_ADDR_W = 3;

    typedef struct packed {
        logic act_lo_n;   // active-low enable
        logic act_hi;     // active-high enable
    } adl_en_t;

    // True when both enables are asserted.
    function automatic logic adl_gate_open(adl_en_t en);
        return (!en.act_lo_n) && en.act_hi;
    endfunction
endpackage

// File: rtl/adl_addr_latch.sv
// Module: address register that models a level latch sampled on the clock.
// Loads the address on every edge with the hold input low and keeps its value
// while hold is high. Assumes a synchronous active-low reset that clears to 0.
module adl_addr_latch #(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic [ADDR_W-1:0] addr_d,
    output logic [ADDR_W-1:0] addr_q
);
    // Stored address: reset, follow, or freeze.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (!hold) begin
            addr_q <= addr_d;
        end
    end
endmodule

// File: rtl/adl_onehot_dec.sv
// Module: binary-to-one-hot decoder with an active-high result.
// Assumes OUT_N equals 2**ADDR_W; exactly one bit is set for any input.
module adl_onehot_dec #(
    parameter int ADDR_W = 3,
    localparam int OUT_N = 1 << ADDR_W
) (
    input  logic [ADDR_W-1:0] sel,
    output logic [OUT_N-1:0]  hot
);
    for (genvar gi = 0; gi < OUT_N; gi++) begin : g_line
        // One comparator per strobe line.
        always_comb hot[gi] = (sel == ADDR_W'(gi));
    end
endmodule

// File: rtl/adl_out_gate.sv
// Module: applies the enable pair to the one-hot vector and inverts it.
// Assumes the input is one-hot or zero; a closed gate drives all ones.
module adl_out_gate #(
    parameter int OUT_N = 8
) (
    input  adl_pkg::adl_en_t en,
    input  logic [OUT_N-1:0] hot,
    output logic [OUT_N-1:0] strobe_n
);
    logic open_w;

    // Gate decision from the enable pair.
    always_comb open_w = adl_pkg::adl_gate_open(en);

    for (genvar gi = 0; gi < OUT_N; gi++) begin : g_bit
        // Each strobe is low only for the selected line through an open gate.
        always_comb strobe_n[gi] = ~(hot[gi] & open_w);
    end
endmodule

// File: rtl/latched_addr_decoder.sv
// Module: top of the latched-address active-low decoder.
// Stored address -> one-hot decode -> enable gate. The enables act without a
// clock; only the address passes through a register. Synchronous active-low reset.
module latched_addr_decoder #(
    parameter int ADDR_W = adl_pkg::ADL_ADDR_W,
    localparam int OUT_N = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              lat_en,
    input  logic              en_lo_n,
    input  logic              en_hi,
    output logic [OUT_N-1:0]  dec_n
);
    logic [ADDR_W-1:0] addr_q;
    logic [OUT_N-1:0]  hot;
    adl_pkg::adl_en_t  en_pair;

    // Bundle the enables for the gate stage.
    always_comb en_pair = '{act_lo_n: en_lo_n, act_hi: en_hi};

    adl_addr_latch #(.ADDR_W(ADDR_W)) latch_i (
        .clk(clk), .rst_n(rst_n), .hold(lat_en), .addr_d(addr_in), .addr_q(addr_q)
    );

    adl_onehot_dec #(.ADDR_W(ADDR_W)) dec_i (
        .sel(addr_q), .hot(hot)
    );

    adl_out_gate #(.OUT_N(OUT_N)) gate_i (
        .en(en_pair), .hot(hot), .strobe_n(dec_n)
    );
endmodule

// File: rtl/adl_checker.sv
// Module: property checker for latched_addr_decoder, attached with bind.
// Watches the ports only. Assumes rst_n is low for the first clock edge.
module adl_checker #(
    parameter int ADDR_W = 3,
    localparam int OUT_N = 1 << ADDR_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr_in,
    input logic              lat_en,
    input logic              en_lo_n,
    input logic              en_hi,
    input logic [OUT_N-1:0]  dec_n
);
    logic open_w;
    logic seen_rst;

    always_comb open_w = !en_lo_n && en_hi;

    // Marks that a reset edge has happened, so history is meaningful.
    always_ff @(posedge clk) begin
        if (!rst_n) seen_rst <= 1'b1;
        else if (seen_rst !== 1'b1) seen_rst <= 1'b0;
    end

    AST_AT_MOST_ONE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~dec_n) <= 1); // R7
    AST_CLOSED_ALL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !open_w |-> (&dec_n)); // R4
    AST_OPEN_ONE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_rst && open_w) |-> ($countones(~dec_n) == 1)); // R5
    AST_RESET_PICKS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_rst && $past(!rst_n) && open_w) |-> !dec_n[0]); // R1
    AST_LOAD_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_rst && $past(rst_n) && $past(!lat_en) && open_w) |-> !dec_n[$past(addr_in)]); // R2
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_rst && $past(rst_n) && $past(lat_en) && open_w && $past(open_w)) |-> $stable(dec_n)); // R3
endmodule

bind latched_addr_decoder adl_checker #(.ADDR_W(ADDR_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .addr_in(addr_in), .lat_en(lat_en),
    .en_lo_n(en_lo_n), .en_hi(en_hi), .dec_n(dec_n)
);

// File: tb/latched_addr_decoder_tb_top.sv
// Bench: directed corners plus seeded random stimulus, checked against a model.
module latched_addr_decoder_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 3;
    localparam int ON = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic          lat_en = 1'b0;
    logic          en_lo_n = 1'b1;
    logic          en_hi = 1'b0;
    logic [ON-1:0] dec_n;

    int n_run = 0;
    int n_fail = 0;
    logic [AW-1:0] model_addr = '0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    latched_addr_decoder #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .addr_in(addr_in), .lat_en(lat_en),
        .en_lo_n(en_lo_n), .en_hi(en_hi), .dec_n(dec_n)
    );

    // Reference strobes from the requirements (R4, R5).
    function automatic logic [ON-1:0] ref_strobes(logic [AW-1:0] a, logic lo_n, logic hi);
        logic [ON-1:0] v = '1;
        if (!lo_n && hi) v[a] = 1'b0;
        return v;
    endfunction

    task automatic check(string req);
        logic [ON-1:0] exp = ref_strobes(model_addr, en_lo_n, en_hi);
        n_run++;
        if (dec_n !== exp) begin
            n_fail++;
            $display("FAIL %s: dec_n=%b expected %b", req, dec_n, exp);
        end
    endtask

    // One clock: drive at the falling edge, update the model at the rising
    // edge, check at the next falling edge.
    task automatic cycle(logic rn, logic [AW-1:0] a, logic le, logic lo_n, logic hi, string req);
        @(negedge clk);
        rst_n = rn; addr_in = a; lat_en = le; en_lo_n = lo_n; en_hi = hi;
        @(posedge clk);
        if (!rn) model_addr = '0;
        else if (!le) model_addr = a;
        @(negedge clk);
        check(req);
    endtask

    // Changing only the enables, checked with no clock edge in between (R4).
    task automatic enables_now(logic lo_n, logic hi, string req);
        #1;
        en_lo_n = lo_n; en_hi = hi;
        #1;
        check(req);
    endtask

    initial begin
        void'($urandom(32'h5EED_0137));
        // R1: reset clears the stored address; strobe 0 is low once the gate opens.
        cycle(1'b0, 3'd5, 1'b0, 1'b0, 1'b1, "R1");
        cycle(1'b0, 3'd6, 1'b0, 1'b1, 1'b0, "R1");
        // R5/R4: every address under every enable combination.
        for (int a = 0; a < ON; a++) begin
            for (int e = 0; e < 4; e++) begin
                cycle(1'b1, AW'(a), 1'b0, e[1], e[0], (e == 1) ? "R5" : "R4");
            end
        end
        // R2: the register follows the pins every cycle while lat_en is low.
        cycle(1'b1, 3'd2, 1'b0, 1'b0, 1'b1, "R2");
        cycle(1'b1, 3'd7, 1'b0, 1'b0, 1'b1, "R2");
        // R3: freeze at 3 and then sweep the address pins.
        cycle(1'b1, 3'd3, 1'b0, 1'b0, 1'b1, "R2");
        for (int a = 0; a < ON; a++) begin
            cycle(1'b1, AW'(a), 1'b1, 1'b0, 1'b1, "R3");
        end
        // R6: close and reopen the gate while holding.
        cycle(1'b1, 3'd0, 1'b1, 1'b1, 1'b1, "R6");
        cycle(1'b1, 3'd6, 1'b1, 1'b0, 1'b0, "R6");
        cycle(1'b1, 3'd1, 1'b1, 1'b0, 1'b1, "R6");
        // R4: the enables act without waiting for a clock.
        enables_now(1'b1, 1'b1, "R4");
        enables_now(1'b0, 1'b1, "R4");
        // R1: reset while holding still clears the address.
        cycle(1'b0, 3'd4, 1'b1, 1'b0, 1'b1, "R1");
        cycle(1'b1, 3'd4, 1'b1, 1'b0, 1'b1, "R1");
        // R2/R3/R7: seeded random mix of latch, gate and address activity.
        for (int i = 0; i < 400; i++) begin
            logic le = ($urandom % 3) == 0;
            logic lo_n = ($urandom % 4) == 0;
            logic hi = ($urandom % 4) != 0;
            cycle(1'b1, AW'($urandom), le, lo_n, hi, le ? "R3" : "R2");
            n_run++;
            if ($countones(~dec_n) > 1) begin
                n_fail++;
                $display("FAIL R7: dec_n=%b expected at most one zero", dec_n);
            end
        end
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule